// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a clocked static memory with a 32-bit data path split into four byte lanes. Every control, address and data input is sampled on the rising clock edge, so a requester only has to meet setup and hold around that edge. An access begins when either of two start strobes is sampled low while all three chip selects are active. One strobe belongs to a general memory controller and the other to a processor. After that, the block produces the remaining beats of a four-word burst itself. It does this with a two-bit beat counter that works only on the lowest two address bits, and the counter moves forward only when the advance input is low.

The beat order follows a mode pin. In linear order the two low bits count upward and wrap within the aligned group of four words. In interleaved order the two low bits of the start address are XORed with the beat index. Writes use either a global write that stores the whole word, or a byte-write master enable that qualifies one enable per lane. Read data leaves the block either in flow-through form, one clock after the access edge, or through an extra output register that adds one more clock. When output enable is high or no read data is present, the output is held at zero and the valid flag is low. The storage depth is set by a parameter. The default is 1024 words, and setting the address width to 15 gives the full 32K-word array.

Top module: `sbsram_top`

## Requirements
- R1: A start strobe is accepted only when sel_a_n=0, sel_b=1 and sel_c_n=0. A strobe sampled while any select is inactive ends the current burst and performs no access. Cycles without a strobe that follow this also perform no access, even if write inputs are active, until a new accepted strobe arrives.
- R2: With order_ilv=0, the beat address for beat index i keeps the upper address bits of the start address and sets its two low bits to (L+i) mod 4, where L is the start address's low two bits.
- R3: With order_ilv=1, the two low bits of beat i are L XOR i, and the upper bits are unchanged.
- R4: In a cycle without a strobe, adv_n=0 moves to the next beat index and adv_n=1 repeats the current beat. After the fourth beat, advancing returns to beat index 0.
- R5: gwr_n=0 writes all four bytes of wdata to the current beat address, whatever the values of bwe_n and lane_wr_n.
- R6: With gwr_n=1 and bwe_n=0, byte lane k (wdata bits 8k+7:8k) is written only when lane_wr_n[k]=0, and the other bytes keep their old contents. With gwr_n=1 and bwe_n=1 the cycle is a read.
- R7: A burst start sampled with cpu_start_n=0 is always a read, and the write inputs are ignored in that cycle. When both strobes are low, the processor strobe takes priority.
- R8: With pipe_en=0, read data for an access sampled at edge k is on dout with dout_valid=1 after edge k.
- R9: With pipe_en=1, the same read data appears one clock later, after edge k+1, and dout_valid stays low after edge k.
- R10: dout is all zero and dout_valid is low whenever oe_n=1 or no read data is present.
- R11: While reset is high and after it is released, dout is zero, dout_valid is low and no burst is in progress.
- R12: A burst started by ctl_start_n=0 applies the write controls in its first beat and in every later beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, taken on a start strobe |
| wdata | input | 32 | Write data for the current beat |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| ctl_start_n | input | 1 | Controller burst start strobe, active low |
| cpu_start_n | input | 1 | Processor burst start strobe, active low (read only) |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write of all four bytes, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| lane_wr_n | input | 4 | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| pipe_en | input | 1 | Read path: 0 flow-through, 1 pipelined |
| dout | output | 32 | Read data, zero when not valid |
| dout_valid | output | 1 | Read data on dout is valid |

## Verification
Most faults inside this block show up as wrong or reordered words on dout during a burst read. A damaged beat counter or order select places the word from a different slot of the aligned group into the beat that follows, and the error is visible one clock after that beat in flow-through mode or two clocks after it in pipelined mode. A wrong lane mask or a write that is not blocked during a processor start does not appear when the write happens. It appears only when the address is read back later, so every write scenario in the bench ends with a read-back burst. A latency or output-gating fault appears as dout_valid rising one clock early or late, or as nonzero data while the output is disabled.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    typedef struct packed {
        cyc_kind_e              kind;
        logic [LANES-1:0]       mask;
    } acc_ctl_t;

    // Low address bits of a beat, given the start bits and the beat index.
    function automatic logic [BEAT_W-1:0] beat_low(
        input logic [BEAT_W-1:0] start_lo,
        input logic [BEAT_W-1:0] idx,
        input burst_order_e      ord
    );
        if (ord == ORDER_INTERLEAVED) begin
            return start_lo ^ idx;
        end
        return start_lo + idx;
    endfunction

    // Lanes that a write stores into; zero means the cycle is a read.
    function automatic logic [LANES-1:0] lane_mask(
        input logic             glob_n,
        input logic             master_n,
        input logic [LANES-1:0] per_lane_n
    );
        if (!glob_n) begin
            return '1;
        end
        if (!master_n) begin
            return ~per_lane_n;
        end
        return '0;
    endfunction

endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_ok,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              adv_n,
    input  burst_order_e      order,
    output logic              acc_live,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              live_q;
    logic [ADDR_W-1:0] start_q;
    logic [BEAT_W-1:0] idx_q;
    logic [BEAT_W-1:0] idx_next;
    logic [HI_W-1:0]   hi_bits;

    assign idx_next = adv_n ? idx_q : idx_q + BEAT_W'(1);
    assign hi_bits  = start_q[ADDR_W-1:BEAT_W];

    always_comb begin
        if (start) begin
            acc_live = start_ok;
            acc_addr = addr_in;
        end else begin
            acc_live = live_q;
            acc_addr = {hi_bits, beat_low(start_q[BEAT_W-1:0], idx_next, order)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= 1'b0;
            start_q <= '0;
            idx_q   <= '0;
        end else if (start) begin
            live_q  <= start_ok;
            start_q <= addr_in;
            idx_q   <= '0;
        end else if (live_q) begin
            idx_q   <= idx_next;
        end
    end

endmodule

// File: rtl/sbsram_mem.sv
module sbsram_mem
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_mask,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we_mask[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/sbsram_out.sv
module sbsram_out #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pipe_en,
    input  logic              oe_n,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);

    logic              pv_q;
    logic [DATA_W-1:0] pd_q;
    logic              sel_v;
    logic [DATA_W-1:0] sel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q <= 1'b0;
            pd_q <= '0;
        end else begin
            pv_q <= rd_hit;
            pd_q <= arr_data;
        end
    end

    assign sel_v      = pipe_en ? pv_q : rd_hit;
    assign sel_d      = pipe_en ? pd_q : arr_data;
    assign dout_valid = sel_v & ~oe_n;
    assign dout       = dout_valid ? sel_d : '0;

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              ctl_start_n,
    input  logic              cpu_start_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwe_n,
    input  logic [3:0]        lane_wr_n,
    input  logic              oe_n,
    input  logic              order_ilv,
    input  logic              pipe_en,
    output logic [31:0]       dout,
    output logic              dout_valid
);

    localparam int DATA_W = LANES * LANE_W;

    logic              cpu_start;
    logic              any_start;
    logic              chip_ok;
    logic              acc_live;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  mask_now;
    cyc_kind_e         kind_now;
    acc_ctl_t          ctl_q;
    logic [ADDR_W-1:0] acc_addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] arr_data;
    burst_order_e      order;

    assign cpu_start = ~cpu_start_n;
    assign any_start = cpu_start | ~ctl_start_n;
    assign chip_ok   = ~sel_a_n & sel_b & ~sel_c_n;
    assign order     = burst_order_e'(order_ilv);

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .start    (any_start),
        .start_ok (chip_ok),
        .addr_in  (addr),
        .adv_n    (adv_n),
        .order    (order),
        .acc_live (acc_live),
        .acc_addr (acc_addr)
    );

    always_comb begin
        mask_now = (any_start && cpu_start) ? '0 : lane_mask(gwr_n, bwe_n, lane_wr_n);
        if (!acc_live) begin
            kind_now = CYC_IDLE;
        end else if (|mask_now) begin
            kind_now = CYC_WRITE;
        end else begin
            kind_now = CYC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '{kind: CYC_IDLE, mask: '0};
            acc_addr_q <= '0;
            wdata_q    <= '0;
        end else begin
            ctl_q.kind <= kind_now;
            ctl_q.mask <= (kind_now == CYC_WRITE) ? mask_now : '0;
            acc_addr_q <= acc_addr;
            wdata_q    <= wdata;
        end
    end

    sbsram_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .we_mask (ctl_q.mask),
        .addr    (acc_addr_q),
        .wdata   (wdata_q),
        .rdata   (arr_data)
    );

    sbsram_out #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .pipe_en    (pipe_en),
        .oe_n       (oe_n),
        .rd_hit     (ctl_q.kind == CYC_READ),
        .arr_data   (arr_data),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk
    import sbsram_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sel_a_n,
    input logic             sel_b,
    input logic             sel_c_n,
    input logic             ctl_start_n,
    input logic             cpu_start_n,
    input logic             gwr_n,
    input logic             oe_n,
    input logic             pipe_en,
    input logic [31:0]      dout,
    input logic             dout_valid,
    input cyc_kind_e        kind_q,
    input logic [LANES-1:0] mask_q
);

    logic strobe;
    logic selected;

    assign strobe   = ~ctl_start_n | ~cpu_start_n;
    assign selected = ~sel_a_n & sel_b & ~sel_c_n;

    assert_deselect_no_access_R1: assert property (@(posedge clk) disable iff (rst)
        (strobe && !selected) |=> (kind_q == CYC_IDLE));

    assert_global_write_all_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctl_start_n && cpu_start_n && selected && !gwr_n) |=> (mask_q == '1));

    assert_cpu_start_reads_R7: assert property (@(posedge clk) disable iff (rst)
        (!cpu_start_n && selected) |=> (kind_q == CYC_READ && mask_q == '0));

    assert_pipe_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (pipe_en && $past(pipe_en) && dout_valid) |-> ($past(kind_q) == CYC_READ));

    assert_oe_blocks_valid_R10: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_valid);

    assert_invalid_is_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !dout_valid |-> (dout == '0));

    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(rst) |-> (!dout_valid && dout == '0));

endmodule

bind sbsram_top sbsram_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .ctl_start_n (ctl_start_n),
    .cpu_start_n (cpu_start_n),
    .gwr_n       (gwr_n),
    .oe_n        (oe_n),
    .pipe_en     (pipe_en),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .kind_q      (ctl_q.kind),
    .mask_q      (ctl_q.mask)
);

// File: tb/tb_sbsram_top.sv
module tb_sbsram_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic              sel_a_n, sel_b, sel_c_n;
    logic              ctl_start_n, cpu_start_n, adv_n;
    logic              gwr_n, bwe_n;
    logic [3:0]        lane_wr_n;
    logic              oe_n, order_ilv, pipe_en;
    logic [31:0]       dout;
    logic              dout_valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] ref_mem [1 << ADDR_W];

    always #(CLK_PERIOD/2) clk = ~clk;

    sbsram_top #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .ctl_start_n(ctl_start_n), .cpu_start_n(cpu_start_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwe_n(bwe_n), .lane_wr_n(lane_wr_n),
        .oe_n(oe_n), .order_ilv(order_ilv), .pipe_en(pipe_en),
        .dout(dout), .dout_valid(dout_valid)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, pass the rising edge, return at the next falling edge.
    task automatic step(input logic cs, input logic cp, input logic adv,
                        input logic gw, input logic bwe, input logic [3:0] bw,
                        input logic [ADDR_W-1:0] a, input logic [31:0] d);
        ctl_start_n = cs; cpu_start_n = cp; adv_n = adv;
        gwr_n = gw; bwe_n = bwe; lane_wr_n = bw; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        ctl_start_n = 1'b1; cpu_start_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwe_n = 1'b1; lane_wr_n = 4'hF;
    endtask

    task automatic end_burst();
        sel_b = 1'b0;
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
        sel_b = 1'b1;
    endtask

    task automatic expect_read(input string tag, input logic [31:0] exp);
        check({tag, " valid"}, {31'd0, dout_valid}, 32'd1);
        check({tag, " data"}, dout, exp);
    endtask

    task automatic t_reset();
        check("R11 reset valid", {31'd0, dout_valid}, 32'd0);
        check("R11 reset data", dout, 32'd0);
    endtask

    // R12, R5, R2: controller-started write burst (linear, start low bits 2), then flow-through read back (R8)
    task automatic t_linear_write_read();
        logic [ADDR_W-1:0] a;
        order_ilv = 1'b0; pipe_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            a = ADDR_W'(12'h010 | ((2 + i) % 4));
            ref_mem[a] = 32'hA000_0000 + 32'(i) * 32'h0101_0101;
            if (i == 0) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, ADDR_W'(12'h012), ref_mem[a]);
            else        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, '0, ref_mem[a]);
        end
        end_burst();
        for (int i = 0; i < 4; i++) begin
            a = ADDR_W'(12'h010 | ((2 + i) % 4));
            if (i == 0) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ADDR_W'(12'h012), '0);
            else        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
            expect_read($sformatf("R2/R5/R8/R12 linear beat %0d", i), ref_mem[a]);
        end
        end_burst();
    endtask

    // R3: interleaved read from start low bits 1 gives slots 1,0,3,2
    task automatic t_interleaved();
        logic [ADDR_W-1:0] a;
        order_ilv = 1'b1;
        for (int i = 0; i < 4; i++) begin
            a = ADDR_W'(12'h010 | (1 ^ i));
            if (i == 0) step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ADDR_W'(12'h011), '0);
            else        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
            expect_read($sformatf("R3 interleaved beat %0d", i), ref_mem[a]);
        end
        end_burst();
        order_ilv = 1'b0;
    endtask

    // R4: hold with adv_n high, then step and wrap past the fourth beat
    task automatic t_advance();
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ADDR_W'(12'h010), '0);
        expect_read("R4 beat0", ref_mem[ADDR_W'(12'h010)]);
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
        expect_read("R4 hold", ref_mem[ADDR_W'(12'h010)]);
        for (int i = 1; i <= 4; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
            expect_read($sformatf("R4 advance %0d", i), ref_mem[ADDR_W'(12'h010 | (i % 4))]);
        end
        end_burst();
    endtask

    // R6: lane mask 4'b1010 writes lanes 0 and 2; master disabled means read
    task automatic t_byte_write();
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, ADDR_W'(12'h020), 32'h1122_3344);
        end_burst();
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b1010, ADDR_W'(12'h020), 32'hAABB_CCDD);
        end_burst();
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, ADDR_W'(12'h020), 32'h9999_9999);
        expect_read("R6 lane write / master off reads", 32'h11BB_33DD);
        end_burst();
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'h0, ADDR_W'(12'h020), '0);
        expect_read("R6 master off left contents", 32'h11BB_33DD);
        end_burst();
    endtask

    // R7: processor start with global write and controller strobe low still reads
    task automatic t_cpu_start();
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, ADDR_W'(12'h020), 32'hDEAD_BEEF);
        expect_read("R7 cpu start reads", 32'h11BB_33DD);
        end_burst();
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ADDR_W'(12'h020), '0);
        expect_read("R7 no write stored", 32'h11BB_33DD);
        end_burst();
    endtask

    // R9: pipelined read appears one edge later
    task automatic t_pipelined();
        pipe_en = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ADDR_W'(12'h012), '0);
        check("R9 not valid after first edge", {31'd0, dout_valid}, 32'd0);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
        expect_read("R9 beat0 one clock late", ref_mem[ADDR_W'(12'h012)]);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
        expect_read("R9 beat1", ref_mem[ADDR_W'(12'h013)]);
        end_burst();
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
        pipe_en = 1'b0;
    endtask

    // R10: output disabled gives zero and no valid
    task automatic t_oe();
        oe_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ADDR_W'(12'h010), '0);
        check("R10 oe off valid", {31'd0, dout_valid}, 32'd0);
        check("R10 oe off data", dout, 32'd0);
        oe_n = 1'b0;
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, '0, '0);
        expect_read("R10 oe back on", ref_mem[ADDR_W'(12'h010)]);
        end_burst();
        check("R10 idle data zero", dout, 32'd0);
    endtask

    // R1: deselected strobe performs no access and later writes are dropped
    task automatic t_deselect();
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, ADDR_W'(12'h030), 32'h55AA_00FF);
        end_burst();
        sel_a_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, ADDR_W'(12'h030), 32'h0BAD_0001);
        check("R1 sel_a_n high no read", {31'd0, dout_valid}, 32'd0);
        sel_a_n = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, ADDR_W'(12'h030), 32'h0BAD_0002);
        check("R1 no burst after deselect", {31'd0, dout_valid}, 32'd0);
        sel_c_n = 1'b1;
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, ADDR_W'(12'h030), 32'h0BAD_0003);
        sel_c_n = 1'b0;
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, ADDR_W'(12'h030), '0);
        expect_read("R1 contents kept", 32'h55AA_00FF);
        end_burst();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        addr = '0; wdata = '0;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        ctl_start_n = 1'b1; cpu_start_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwe_n = 1'b1; lane_wr_n = 4'hF;
        oe_n = 1'b0; order_ilv = 1'b0; pipe_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_linear_write_read();
        t_interleaved();
        t_advance();
        t_byte_write();
        t_cpu_start();
        t_pipelined();
        t_oe();
        t_deselect();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule